// File: doc/BRIEF.md
# IR pulse/space capture receiver

This block turns the output of an infrared demodulator into a stream of raw symbols that software decodes. The input idles high. Each symbol starts when the input falls. The block then counts how long the input stays low (the pulse) and how long the following high lasts (the space). The pair is packed into one 32-bit word and pushed into a receive FIFO. Durations are counted in ticks of ten prescaled microseconds. The input first passes a two-flop synchronizer and a short glitch filter.

A symbol closes normally at the next falling edge. If pulse plus space reaches a programmable maximum first, the symbol is closed as a timeout, so an idle line ends the stream. The FIFO is read one word at a time through a small register port. Interrupts report FIFO level reached, timeout and overflow. Each can be masked, and each is cleared by writing one. On overflow the FIFO keeps what it holds, and software must drain it before the overflow flag can be cleared.

Register word addresses (reg_addr): 0 enable (bit 0), 1 config, 2 busy, 3 start, 4 symbol count, 5 data pop, 6 mask, 7 status, 8 clear. The config word holds maximum width in [31:16], symbol format in [15:14], interrupt level in [13:8], raw-mode bit in bit 7 and prescaler in [6:0].

Top module: `ir_symbol_capture`

## Requirements
- R1: After reset, count, busy and status read 0, irq is 0, mask reads 7 and config reads 0x3E80_0080.
- R2: Writing 1 to enable bit 0 when it was 0 makes busy read 1 for READY_CYCLES (8) cycles, then 0. A start write is ignored while disabled or busy. Writing 0 to enable stops capture.
- R3: A symbol begins at a filtered falling edge and closes at the next falling edge. It pushes {space, pulse}, with the pulse tick count in [15:0] and the space tick count in [31:16].
- R4: When pulse plus space reaches config[31:16], the current counts are pushed and raw timeout (status bit 25) is set. A line left high after a pulse p gives {max-p, p}. A line stuck low gives {0, max}.
- R5: Input levels that last fewer than FILT_LEN (3) clocks have no effect on the measured durations.
- R6: The count register returns the FIFO occupancy. Each data read pops the oldest word. A data read of an empty FIFO returns 0 and changes nothing.
- R7: Raw receive (status bit 24) is set when a push leaves the occupancy at or above config[13:8]+1.
- R8: A push into a full FIFO is dropped, the stored words are kept, and raw overflow (status bit 26) is set.
- R9: Writing 1 to clear-register bits 16 and 17 clears raw receive and raw timeout. Bit 18 clears raw overflow only while the FIFO is empty.
- R10: Mask bits 0, 1 and 2 suppress receive, timeout and overflow. Status bits 8 to 10 show raw AND NOT mask, and irq is the OR of those bits.
- R11: One tick lasts UNITS_PER_TICK (10) times (config[6:0]+1) clock cycles.
- R12: The config register reads back the full word last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated IR input, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt, OR of unmasked raw flags |

## Verification
Seeded random bursts of pulse/space pairs, each ended by a timeout, check that pulse and space land in the right halves of every word and in order. Directed streams cover the rest. A symbol with pulse plus space one tick under the maximum and one exactly at it separates the normal close from the timeout close. A stuck-low line and a short glitch inside a space separate true edges from filtered noise. A second prescaler setting confirms the tick length. A 66-symbol stream shows overflow retention and the clear that is refused while the FIFO is full. Reads at chosen points of a stream show the level flag switching at the exact occupancy.

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture #(
  parameter int DEPTH = 64,
  parameter int FILT_LEN = 3,
  parameter int READY_CYCLES = 8,
  parameter int UNITS_PER_TICK = 10,
  parameter logic [15:0] MAXW_RESET = 16'h3E80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int FW = $clog2(FILT_LEN) + 1;
  localparam int RW = $clog2(READY_CYCLES + 1);
  localparam int UW = (UNITS_PER_TICK > 1) ? $clog2(UNITS_PER_TICK) : 1;

  localparam logic [3:0] A_EN = 4'd0, A_CFG = 4'd1, A_BUSY = 4'd2, A_START = 4'd3,
                         A_COUNT = 4'd4, A_DATA = 4'd5, A_MASK = 4'd6, A_STAT = 4'd7,
                         A_CLR = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  logic [1:0]    sync_q;
  logic          filt_q, filt_d1;
  logic [FW-1:0] fcnt;
  logic          en_q, cap_q;
  logic [RW-1:0] busy_cnt;
  logic [31:0]   cfg_q;
  logic [2:0]    mask_q, raw_q;
  logic [6:0]    pre_cnt;
  logic [UW-1:0] dec_cnt;
  st_t           st;
  logic [15:0]   pcnt, scnt;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  wire wr_en    = reg_wr && reg_addr == A_EN;
  wire wr_cfg   = reg_wr && reg_addr == A_CFG;
  wire wr_start = reg_wr && reg_addr == A_START;
  wire wr_mask  = reg_wr && reg_addr == A_MASK;
  wire wr_clr   = reg_wr && reg_addr == A_CLR;
  wire stop     = wr_en && !reg_wdata[0];
  wire start_ok = wr_start && en_q && busy_cnt == '0 && !stop;

  wire fall = filt_d1 && !filt_q;
  wire rise = !filt_d1 && filt_q;

  // input conditioning
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11; filt_q <= 1'b1; filt_d1 <= 1'b1; fcnt <= '0;
    end else begin
      sync_q  <= {sync_q[0], ir_in};
      filt_d1 <= filt_q;
      if (sync_q[1] == filt_q) fcnt <= '0;
      else if (fcnt == FW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        fcnt   <= '0;
      end else fcnt <= fcnt + 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cap_q <= 1'b0; busy_cnt <= '0; mask_q <= 3'b111;
      cfg_q <= {MAXW_RESET, 2'b00, 6'd0, 1'b1, 7'd0};
    end else begin
      if (wr_en) en_q <= reg_wdata[0];
      if (wr_en && reg_wdata[0] && !en_q) busy_cnt <= RW'(READY_CYCLES);
      else if (stop) busy_cnt <= '0;
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (stop) cap_q <= 1'b0;
      else if (start_ok) cap_q <= 1'b1;
      if (wr_cfg) cfg_q <= reg_wdata;
      if (wr_mask) mask_q <= reg_wdata[2:0];
    end
  end

  // tick generator
  wire pre_wrap = pre_cnt >= cfg_q[6:0];
  wire dec_last = dec_cnt == UW'(UNITS_PER_TICK - 1);
  wire tick     = cap_q && pre_wrap && dec_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0; dec_cnt <= '0;
    end else if (!cap_q || start_ok) begin
      pre_cnt <= '0; dec_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      dec_cnt <= dec_last ? '0 : dec_cnt + 1'b1;
    end else pre_cnt <= pre_cnt + 1'b1;
  end

  // symbol measurement
  wire [15:0] p_inc = (st == S_LOW && tick && pcnt != 16'hFFFF) ? pcnt + 1'b1 : pcnt;
  wire [15:0] s_inc = (st == S_HIGH && tick && scnt != 16'hFFFF) ? scnt + 1'b1 : scnt;
  wire [16:0] sum   = {1'b0, p_inc} + {1'b0, s_inc};
  wire tmo_evt = cap_q && st != S_IDLE && sum >= {1'b0, cfg_q[31:16]};
  wire push    = tmo_evt || (cap_q && st == S_HIGH && fall);
  wire [31:0] push_word = {s_inc, p_inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pcnt <= '0; scnt <= '0;
    end else if (!cap_q || start_ok) begin
      st <= S_IDLE; pcnt <= '0; scnt <= '0;
    end else if (tmo_evt) begin
      st <= fall ? S_LOW : S_IDLE; pcnt <= '0; scnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (fall) begin st <= S_LOW; pcnt <= '0; scnt <= '0; end
        S_LOW: begin
          pcnt <= p_inc;
          if (rise) st <= S_HIGH;
        end
        default: begin
          scnt <= s_inc;
          if (fall) begin st <= S_LOW; pcnt <= '0; scnt <= '0; end
        end
      endcase
    end
  end

  // receive FIFO
  wire full    = cnt == CW'(DEPTH);
  wire do_push = push && !full;
  wire pop     = reg_rd && reg_addr == A_DATA && cnt != '0;
  wire [CW-1:0] cnt_nxt = cnt + CW'(do_push) - CW'(pop);

  always_ff @(posedge clk) if (do_push) mem[wr_ptr] <= push_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  // interrupt flags: raw_q = {overflow, timeout, receive}
  wire rx_set = do_push && (32'(cnt_nxt) > 32'(cfg_q[13:8]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else begin
      if (rx_set) raw_q[0] <= 1'b1;
      else if (wr_clr && reg_wdata[16]) raw_q[0] <= 1'b0;
      if (tmo_evt) raw_q[1] <= 1'b1;
      else if (wr_clr && reg_wdata[17]) raw_q[1] <= 1'b0;
      if (push && full) raw_q[2] <= 1'b1;
      else if (wr_clr && reg_wdata[18] && cnt == '0) raw_q[2] <= 1'b0;
    end
  end

  wire [2:0] masked = raw_q & ~mask_q;
  assign irq = |masked;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:    reg_rdata = {31'd0, en_q};
      A_CFG:   reg_rdata = cfg_q;
      A_BUSY:  reg_rdata = {31'd0, busy_cnt != '0};
      A_COUNT: reg_rdata = 32'(cnt);
      A_DATA:  reg_rdata = (cnt != '0) ? mem[rd_ptr] : '0;
      A_MASK:  reg_rdata = {29'd0, mask_q};
      A_STAT:  reg_rdata = {5'd0, raw_q, 13'd0, masked, 8'd0};
      default: reg_rdata = '0;
    endcase
  end

  assert_busy_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_wdata[0] && !en_q) |=> (busy_cnt != '0));
  assert_cap_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |-> en_q);
  assert_tmo_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> raw_q[1]);
  assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !do_push) |=> (cnt == $past(cnt) - CW'(1)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (raw_q[2] && $stable(wr_ptr)));
  assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[2] && wr_clr && reg_wdata[18] && cnt != '0) |=> raw_q[2]);
endmodule

// File: tb/ir_symbol_capture_test.sv
module ir_symbol_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 50;
  localparam logic [3:0] A_EN = 4'd0, A_CFG = 4'd1, A_BUSY = 4'd2, A_START = 4'd3,
                         A_COUNT = 4'd4, A_DATA = 4'd5, A_MASK = 4'd6, A_STAT = 4'd7,
                         A_CLR = 4'd8;

  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;

  ir_symbol_capture uut (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] expq [0:127];
  logic [31:0] d;
  int unused_seed;

  function automatic logic [31:0] pack(int p, int s);
    return {s[15:0], p[15:0]};
  endfunction

  function automatic logic [31:0] cfg_word(int maxw, int lvl, int presc);
    return {maxw[15:0], 2'b00, lvl[5:0], 1'b1, presc[6:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic send_sym(int p, int s, int tk);
    ir_in = 1'b0; repeat (p * tk) @(negedge clk);
    ir_in = 1'b1; repeat (s * tk) @(negedge clk);
  endtask

  task automatic idle(int ticks, int tk);
    ir_in = 1'b1; repeat ((ticks + 3) * tk) @(negedge clk);
  endtask

  task automatic drain(int n, string req);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      rd(A_DATA, v);
      check(req, v, expq[i]);
    end
  endtask

  task automatic burst(int k);
    int p, s;
    logic [31:0] v;
    for (int i = 0; i < k; i++) begin
      p = $urandom_range(1, 20);
      s = $urandom_range(1, 20);
      send_sym(p, s, 10);
      expq[i] = (i < k - 1) ? pack(p, s) : pack(p, MAXW - p);
    end
    idle(MAXW, 10);
    rd(A_COUNT, v);
    check("R6 burst count", v, k);
    drain(k, "R3 burst word");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'd1207);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_COUNT, d); check("R1 count", d, 0);
    rd(A_BUSY, d);  check("R1 busy", d, 0);
    rd(A_STAT, d);  check("R1 status", d, 0);
    rd(A_MASK, d);  check("R1 mask", d, 7);
    rd(A_CFG, d);   check("R1 config", d, 32'h3E80_0080);
    check("R1 irq", 32'(irq), 0);

    // R2 enable, busy window, ignored start
    wr(A_START, 1);
    send_sym(3, 3, 10); send_sym(3, 3, 10); idle(5, 10);
    rd(A_COUNT, d); check("R2 start while disabled", d, 0);
    wr(A_EN, 1);
    rd(A_BUSY, d); check("R2 busy after enable", d, 1);
    wr(A_START, 1);
    repeat (20) @(negedge clk);
    rd(A_BUSY, d); check("R2 busy released", d, 0);
    send_sym(3, 3, 10); send_sym(3, 3, 10); idle(5, 10);
    rd(A_COUNT, d); check("R2 start while busy", d, 0);

    // R12 config and capture start
    wr(A_CFG, cfg_word(MAXW, 3, 0));
    rd(A_CFG, d); check("R12 config readback", d, cfg_word(MAXW, 3, 0));
    wr(A_START, 1);

    // R3 random bursts
    for (int b = 0; b < 3; b++) burst(5 + b);
    rd(A_STAT, d); check("R4 R7 raw after bursts", d & 32'h0700_0700, 32'h0300_0000);
    wr(A_CLR, 32'h0003_0000);
    rd(A_STAT, d); check("R9 clear rx and timeout", d, 0);

    // R7 level threshold, R4 stuck low
    send_sym(2, 3, 10); send_sym(4, 2, 10); send_sym(3, 3, 10);
    ir_in = 1'b0; repeat (10) @(negedge clk);
    rd(A_COUNT, d); check("R7 count three", d, 3);
    rd(A_STAT, d);  check("R7 below threshold", d & 32'h0100_0000, 0);
    ir_in = 1'b1; repeat (30) @(negedge clk);
    ir_in = 1'b0; repeat (10) @(negedge clk);
    rd(A_STAT, d);  check("R7 threshold reached", d & 32'h0100_0000, 32'h0100_0000);
    repeat ((MAXW + 3) * 10) @(negedge clk);
    ir_in = 1'b1; repeat (20) @(negedge clk);
    rd(A_COUNT, d); check("R4 stuck low count", d, 5);
    expq[0] = pack(2, 3); expq[1] = pack(4, 2); expq[2] = pack(3, 3);
    drain(3, "R3 directed word");
    rd(A_DATA, d);
    rd(A_DATA, d); check("R4 stuck low word", d, pack(MAXW, 0));
    rd(A_DATA, d); check("R6 empty read", d, 0);
    rd(A_COUNT, d); check("R6 empty count", d, 0);
    wr(A_CLR, 32'h0007_0000);

    // R5 glitch inside a space
    ir_in = 1'b0; repeat (50) @(negedge clk);
    ir_in = 1'b1; repeat (30) @(negedge clk);
    ir_in = 1'b0; repeat (2) @(negedge clk);
    ir_in = 1'b1; repeat (38) @(negedge clk);
    send_sym(4, 0, 10); idle(MAXW, 10);
    rd(A_COUNT, d); check("R5 glitch count", d, 2);
    expq[0] = pack(5, 7); expq[1] = pack(4, MAXW - 4);
    drain(2, "R5 glitch word");

    // R4 boundary: sum one under maximum, then exactly at it
    send_sym(20, 29, 10); send_sym(20, 30, 10); send_sym(3, 0, 10); idle(MAXW, 10);
    rd(A_COUNT, d); check("R4 boundary count", d, 3);
    expq[0] = pack(20, 29); expq[1] = pack(20, 30); expq[2] = pack(3, MAXW - 3);
    drain(3, "R4 boundary word");
    wr(A_CLR, 32'h0007_0000);

    // R11 prescaler of one doubles the tick
    wr(A_CFG, cfg_word(MAXW, 3, 1));
    send_sym(2, 3, 20); send_sym(1, 0, 20); idle(MAXW, 20);
    expq[0] = pack(2, 3); expq[1] = pack(1, MAXW - 1);
    drain(2, "R11 prescaled word");
    wr(A_CFG, cfg_word(MAXW, 3, 0));

    // R10 masking
    rd(A_STAT, d); check("R10 all masked", d, 32'h0200_0000);
    check("R10 irq masked", 32'(irq), 0);
    wr(A_MASK, 3'b101);
    rd(A_STAT, d); check("R10 timeout unmasked", d, 32'h0200_0200);
    check("R10 irq raised", 32'(irq), 1);
    wr(A_CLR, 32'h0002_0000);
    check("R9 irq after clear", 32'(irq), 0);
    wr(A_MASK, 3'b111);

    // R8 overflow retention, R9 refused clear
    for (int i = 0; i < 66; i++) begin
      send_sym(i % 5 + 1, 2, 10);
      if (i < 64) expq[i] = pack(i % 5 + 1, 2);
    end
    idle(MAXW, 10);
    rd(A_COUNT, d); check("R8 full count", d, 64);
    rd(A_STAT, d);  check("R8 overflow raw", d & 32'h0400_0000, 32'h0400_0000);
    wr(A_CLR, 32'h0004_0000);
    rd(A_STAT, d);  check("R9 clear refused while full", d & 32'h0400_0000, 32'h0400_0000);
    drain(64, "R8 retained word");
    wr(A_CLR, 32'h0004_0000);
    rd(A_STAT, d);  check("R9 clear after drain", d & 32'h0400_0000, 0);

    // R2 disable stops capture
    wr(A_EN, 0);
    send_sym(3, 3, 10); send_sym(3, 3, 10); idle(MAXW, 10);
    rd(A_COUNT, d); check("R2 disabled no capture", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule